// File: doc/BRIEF.md
# Endpoint Event Interrupt Aggregator with End-of-Interrupt Gating

This block gathers single-cycle event pulses from a USB controller into one 32-bit pending word. The pulses are per-endpoint transmit completions, per-endpoint receive completions, and a group of nine core events whose top member reports a change of the VBUS-drive request. Software programs an enable mask and reads a masked view of the pending word. It receives one level interrupt line.

Pending and enable state change only through dedicated set and clear aliases. Each 1 written to an alias sets or clears one bit, and each 0 leaves its bit alone. This lets software acknowledge or inject single events without a read-modify-write. After the interrupt line rises, it cannot rise again until software writes the end-of-interrupt register, even if enabled events are still pending. This keeps the interrupt service routine from re-entering before it has finished.

The register port is a plain 32-bit write strobe with a byte address. Read data is returned combinationally from the address. The word offsets are fixed, because software decodes them.

Top module: `evt_irq_hub`

## Requirements
- R1: After synchronous active-high reset, the pending word and the enable mask are zero, the interrupt output is low, and the end-of-interrupt gate is open.
- R2: A pulse on `tx_evt[i]` sets pending bit i (bits 4:0). A pulse on `rx_evt[j]` sets pending bit 9+j (bits 12:9). A pulse on `core_evt[k]` sets pending bit 16+k (bits 24:16), and bit 24 is the VBUS-drive change. A hardware pulse and a software clear of the same bit in the same cycle leave the bit set.
- R3: Writing word offset 0x24 sets every pending bit written as 1. The pending word reads back at offset 0x20.
- R4: Writing offset 0x28 clears every pending bit written as 1. Bits written as 0 keep their value.
- R5: Writing offset 0x30 sets enable bits and writing offset 0x34 clears enable bits, one bit per written 1. The enable mask reads back at offset 0x2C.
- R6: Offset 0x38 reads the pending word ANDed with the enable mask.
- R7: Bits 31:25, 15:13 and 8:5 are reserved. They read as zero and cannot be set. Reads of offsets 0x24, 0x28, 0x30, 0x34 and 0x3C return zero.
- R8: The interrupt output is registered. It rises one cycle after the masked word becomes nonzero while the gate is open, and it falls one cycle after the masked word becomes zero.
- R9: Once the output has risen, it does not rise again until a write to offset 0x3C, whatever the written data. That write drives the output low and reopens the gate, so the output rises again one cycle later if masked events are still pending.
- R10: Pending events whose enable bit is clear never raise the output. Clearing the enable bit of the only pending event lowers the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_evt | input | 5 | Transmit-endpoint event pulses |
| rx_evt | input | 4 | Receive-endpoint event pulses |
| core_evt | input | 9 | Core event pulses, top bit is the VBUS-drive change |
| irq | output | 1 | Level interrupt output |

## Verification
The mapping of hardware pulses into the word is tried with a sparse mix of transmit, receive and VBUS-drive pulses. This shows whether each group lands at its own field position. An all-ones write to the set alias shows reserved bits apart from usable ones, and a clear that overlaps a hardware pulse on the same bit shows which of the two wins. The interrupt line is driven through a sequence of rise, fall on acknowledge, re-pend with the gate closed, and then end-of-interrupt with and without pending events. This separates a level that follows the masked word from a line that is gated by the end-of-interrupt write.

// File: rtl/evt_irq_hub_pkg.sv
package evt_irq_hub_pkg;

  localparam int DATA_W   = 32;
  localparam int TX_N     = 5;
  localparam int RX_N     = 4;
  localparam int CORE_N   = 9;
  localparam int TX_LSB   = 0;
  localparam int RX_LSB   = 9;
  localparam int CORE_LSB = 16;

  // word indexes (byte offset >> 2) that software decodes
  localparam int WI_SRC_RAW  = 8;
  localparam int WI_SRC_SET  = 9;
  localparam int WI_SRC_CLR  = 10;
  localparam int WI_MSK_RAW  = 11;
  localparam int WI_MSK_SET  = 12;
  localparam int WI_MSK_CLR  = 13;
  localparam int WI_MASKED   = 14;
  localparam int WI_EOI      = 15;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_SRC    = 2'd1,
    RSEL_MSK    = 2'd2,
    RSEL_MASKED = 2'd3
  } rsel_e;

  function automatic logic [DATA_W-1:0] field_ones(input int lsb, input int n);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (b >= lsb && b < lsb + n) v[b] = 1'b1;
    end
    return v;
  endfunction

  // usable bits; receive endpoint 0 slot (RX_LSB-1) stays reserved
  function automatic logic [DATA_W-1:0] usable_bits();
    return field_ones(TX_LSB, TX_N) | field_ones(RX_LSB, RX_N) |
           field_ones(CORE_LSB, CORE_N);
  endfunction

  function automatic logic [DATA_W-1:0] place_events(
    input logic [TX_N-1:0]   tx,
    input logic [RX_N-1:0]   rx,
    input logic [CORE_N-1:0] core
  );
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < TX_N; i++)   w[TX_LSB + i]   = tx[i];
    for (int i = 0; i < RX_N; i++)   w[RX_LSB + i]   = rx[i];
    for (int i = 0; i < CORE_N; i++) w[CORE_LSB + i] = core[i];
    return w;
  endfunction

  // set wins over clear for the same bit in the same cycle
  function automatic logic next_bit(input logic cur, input logic set_b,
                                    input logic clr_b);
    return set_b | (cur & ~clr_b);
  endfunction

endpackage

// File: rtl/evt_irq_regdec.sv
module evt_irq_regdec
  import evt_irq_hub_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  output logic              src_set_wr,
  output logic              src_clr_wr,
  output logic              msk_set_wr,
  output logic              msk_clr_wr,
  output logic              eoi_wr,
  output rsel_e             rsel
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              unused_byte_lane;

  assign word             = reg_addr[ADDR_W-1:2];
  assign unused_byte_lane = ^reg_addr[1:0];

  function automatic logic hit(input logic [WORD_W-1:0] w, input int idx);
    return w == WORD_W'(idx);
  endfunction

  assign src_set_wr = reg_wr && hit(word, WI_SRC_SET);
  assign src_clr_wr = reg_wr && hit(word, WI_SRC_CLR);
  assign msk_set_wr = reg_wr && hit(word, WI_MSK_SET);
  assign msk_clr_wr = reg_wr && hit(word, WI_MSK_CLR);
  assign eoi_wr     = reg_wr && hit(word, WI_EOI);

  always_comb begin
    rsel = RSEL_NONE;
    if (hit(word, WI_SRC_RAW))      rsel = RSEL_SRC;
    else if (hit(word, WI_MSK_RAW)) rsel = RSEL_MSK;
    else if (hit(word, WI_MASKED))  rsel = RSEL_MASKED;
  end

endmodule

// File: rtl/evt_irq_bitreg.sv
module evt_irq_bitreg
  import evt_irq_hub_pkg::*;
#(
  parameter int               W     = DATA_W,
  parameter logic [W-1:0]     USED  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] hw_set,
  input  logic         sw_set_en,
  input  logic         sw_clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (USED[i]) begin : g_used
      logic set_b;
      logic clr_b;
      assign set_b = hw_set[i] | (sw_set_en & wdata[i]);
      assign clr_b = sw_clr_en & wdata[i];
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= next_bit(q[i], set_b, clr_b);
      end
    end else begin : g_resv
      logic unused_in;
      assign unused_in = hw_set[i] ^ wdata[i];
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic eoi_wr,
  output logic irq,
  output logic gate_open,
  output logic rise_evt
);

  assign rise_evt = !irq && gate_open && pending && !eoi_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      gate_open <= 1'b1;
    end else if (eoi_wr) begin
      irq       <= 1'b0;
      gate_open <= 1'b1;
    end else if (rise_evt) begin
      irq       <= 1'b1;
      gate_open <= 1'b0;
    end else if (irq) begin
      irq       <= pending;
    end
  end

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_hub_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [CORE_N-1:0] core_evt,
  output logic              irq
);

  localparam logic [DATA_W-1:0] USED = usable_bits();

  logic              src_set_wr, src_clr_wr, msk_set_wr, msk_clr_wr, eoi_wr;
  rsel_e             rsel;
  logic [DATA_W-1:0] hw_evt_w;
  logic [DATA_W-1:0] src_w;
  logic [DATA_W-1:0] mask_w;
  logic [DATA_W-1:0] masked_w;
  logic              pending_w;
  logic              gate_open;
  logic              rise_evt;

  evt_irq_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .src_set_wr (src_set_wr),
    .src_clr_wr (src_clr_wr),
    .msk_set_wr (msk_set_wr),
    .msk_clr_wr (msk_clr_wr),
    .eoi_wr     (eoi_wr),
    .rsel       (rsel)
  );

  assign hw_evt_w = place_events(tx_evt, rx_evt, core_evt);

  evt_irq_bitreg #(.W(DATA_W), .USED(USED)) u_src (
    .clk       (clk),
    .rst       (rst),
    .hw_set    (hw_evt_w),
    .sw_set_en (src_set_wr),
    .sw_clr_en (src_clr_wr),
    .wdata     (reg_wdata),
    .q         (src_w)
  );

  evt_irq_bitreg #(.W(DATA_W), .USED(USED)) u_msk (
    .clk       (clk),
    .rst       (rst),
    .hw_set    ('0),
    .sw_set_en (msk_set_wr),
    .sw_clr_en (msk_clr_wr),
    .wdata     (reg_wdata),
    .q         (mask_w)
  );

  assign masked_w  = src_w & mask_w;
  assign pending_w = |masked_w;

  evt_irq_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .pending   (pending_w),
    .eoi_wr    (eoi_wr),
    .irq       (irq),
    .gate_open (gate_open),
    .rise_evt  (rise_evt)
  );

  always_comb begin
    case (rsel)
      RSEL_SRC:    reg_rdata = src_w;
      RSEL_MSK:    reg_rdata = mask_w;
      RSEL_MASKED: reg_rdata = masked_w;
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk
  import evt_irq_hub_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              gate_open,
  input logic              eoi_wr,
  input logic              msk_clr_wr,
  input logic [31:0]       wdata,
  input logic [DATA_W-1:0] hw_evt,
  input logic [DATA_W-1:0] src,
  input logic [DATA_W-1:0] mask,
  input logic [DATA_W-1:0] masked
);

  // R2
  hw_pulse_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (|hw_evt) |=> ((src & $past(hw_evt)) == $past(hw_evt)));

  // R5
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    msk_clr_wr |=> ((mask & $past(wdata)) == '0));

  // R8
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|masked));

  // R9
  rise_needs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(gate_open));

  // R9
  closed_gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && !gate_open && !eoi_wr) |=> !irq);

  // R9
  eoi_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_wr |=> (gate_open && !irq));

endmodule

bind evt_irq_hub evt_irq_hub_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .gate_open  (gate_open),
  .eoi_wr     (eoi_wr),
  .msk_clr_wr (msk_clr_wr),
  .wdata      (reg_wdata),
  .hw_evt     (hw_evt_w),
  .src        (src_w),
  .mask       (mask_w),
  .masked     (masked_w)
);

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  tx_evt = '0;
  logic [3:0]  rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // usable bits: 4:0, 12:9, 24:16
  localparam logic [31:0] USABLE = 32'h01FF_1E1F;

  evt_irq_hub uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .core_evt(core_evt), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h20, d); check("R1 pending after reset", d, 32'h0);
    rd(8'h2C, d); check("R1 mask after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_hw_events;
    logic [31:0] d;
    @(negedge clk);
    tx_evt = 5'b10101; rx_evt = 4'b1001; core_evt = 9'h100;
    @(negedge clk);
    tx_evt = '0; rx_evt = '0; core_evt = '0;
    rd(8'h20, d);
    check("R2 hw pulses placed", d, 32'h0100_1215);
    idle(2);
    check("R10 masked-off events keep irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_src_clear;
    logic [31:0] d;
    wr(8'h28, 32'h0000_0015);
    rd(8'h20, d); check("R4 clear acknowledges ones", d, 32'h0100_1200);
    wr(8'h28, 32'h0);
    rd(8'h20, d); check("R4 zero write no effect", d, 32'h0100_1200);
  endtask

  task automatic t_src_set;
    logic [31:0] d;
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R3 R7 set all usable only", d, USABLE);
    rd(8'h24, d); check("R7 set alias reads zero", d, 32'h0);
    rd(8'h28, d); check("R7 clear alias reads zero", d, 32'h0);
    rd(8'h30, d); check("R7 mask set alias reads zero", d, 32'h0);
    rd(8'h34, d); check("R7 mask clear alias reads zero", d, 32'h0);
    rd(8'h3C, d); check("R7 eoi reads zero", d, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, d); check("R4 clear all", d, 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h30, 32'hFE00_0003);
    rd(8'h2C, d); check("R5 R7 mask set", d, 32'h0000_0003);
    wr(8'h34, 32'h0000_0001);
    rd(8'h2C, d); check("R5 mask clear", d, 32'h0000_0002);
  endtask

  task automatic t_irq_gate;
    logic [31:0] d;
    wr(8'h24, 32'h0000_0006);
    rd(8'h38, d); check("R6 masked view", d, 32'h0000_0002);
    check("R8 irq not yet risen", {31'b0, irq}, 32'h0);
    idle(1);
    check("R8 irq risen", {31'b0, irq}, 32'h1);
    wr(8'h28, 32'h0000_0002);
    check("R8 irq still high same cycle", {31'b0, irq}, 32'h1);
    idle(1);
    check("R8 irq falls after ack", {31'b0, irq}, 32'h0);
    wr(8'h24, 32'h0000_0002);
    idle(3);
    check("R9 no rise before eoi", {31'b0, irq}, 32'h0);
    wr(8'h3C, 32'h0000_1234);
    check("R9 eoi cycle low", {31'b0, irq}, 32'h0);
    idle(1);
    check("R9 rises after eoi", {31'b0, irq}, 32'h1);
    wr(8'h28, 32'hFFFF_FFFF);
    idle(2);
    wr(8'h3C, 32'h0);
    idle(2);
    check("R9 eoi with nothing pending", {31'b0, irq}, 32'h0);
    wr(8'h24, 32'h0000_0002);
    idle(1);
    check("R8 rise with gate open", {31'b0, irq}, 32'h1);
    wr(8'h34, 32'h0000_0002);
    idle(1);
    check("R10 mask clear lowers irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    reg_addr = 8'h28; reg_wdata = 32'h0100_0001; reg_wr = 1'b1;
    tx_evt = 5'b00001; core_evt = 9'h100;
    @(negedge clk);
    reg_wr = 1'b0; tx_evt = '0; core_evt = '0;
    rd(8'h20, d);
    check("R2 hw set beats sw clear", d & 32'h0100_0001, 32'h0100_0001);
  endtask

  initial begin
    fork
      begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_hw_events();
        t_src_clear();
        t_src_set();
        t_mask();
        t_irq_gate();
        t_set_wins();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog expired");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule